// File: doc/BRIEF.md
# Grouped interrupt cause controller

This block gathers single-cycle event pulses from a datapath into three cause groups (transmit, receive and miscellaneous) and presents them to a host over a small register bus. Every group keeps a raw cause register, a per-bit mask, and a mode register. The mask is changed through two write-only registers: one sets mask bits and the other clears them. The mode register decides whether the host acknowledges causes by writing ones or whether a read of the cause register acknowledges them itself. The mode can change at run time.

A summary register holds one bit per group. A bit rises when its group has at least one unmasked cause bit pending. A host read of the summary clears it, so no separate acknowledge write is needed. The summary has its own mask. The single level interrupt line is the OR of the summary bits that this mask lets through. The host reads the summary and then services each group it names. The summary only ever uses its three low bits, so a genuine event never reads back as zero or as a value whose low byte is all ones. Host software treats both of those patterns as no interrupt.

Word address map: group g (TX=0, RX=1, MISC=2) occupies addresses 8g to 8g+5. Offset 0 is the cause register, 1 is mask set, 2 is mask clear, 3 is the mode register, 4 is the masked-cause view and 5 is the mask value. The summary register is at address 24 and the summary mask at address 25.

Top module: `grp_irq_ctrl`

## Requirements
- R1: After reset every cause register reads 0, every group mask reads all ones, every mode register reads 0 (acknowledge by write), the summary mask reads 0x7, the summary reads 0 and irq_o is low.
- R2: An event pulse on bit i of a group sets cause bit i on the next clock edge whether or not that bit is masked, and the bit stays set until it is acknowledged.
- R3: In acknowledge-by-write mode, writing the cause register clears the bits written as one and leaves bits written as zero unchanged; reading the cause register does not change it.
- R4: Writing all ones to a mode register selects clear-on-read, in which a cause read returns the value and clears the bits returned, and cause writes are ignored. Writing any other value selects acknowledge-by-write. The mode register reads back as all ones or zero.
- R5: A write to mask set sets the mask bits written as one; a write to mask clear clears the mask bits written as one; zero bits leave the mask unchanged.
- R6: The masked-cause view reads cause AND NOT mask; the mask view reads the current mask.
- R7: Summary bit 0 is TX, bit 1 is RX, bit 2 is MISC. A summary bit is set on the clock edge after its group holds an unmasked cause bit, regardless of the summary mask. The summary bits above bit 2 always read zero.
- R8: A summary bit stays set after its group's condition goes away, until a summary read clears it. A read while the condition persists leaves the bit set.
- R9: The summary mask is written and read in its low 3 bits (one blocks). irq_o is high exactly when some summary bit is set and not blocked, so writing all ones holds irq_o low.
- R10: When an event pulse for a bit coincides with an acknowledge of that bit, either by write or by clear-on-read, the bit remains set.
- R11: Read data appears on bus_rdata from the clock edge that samples bus_rd and holds until the next read; unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_tx | input | DATA_W | Transmit event pulses, one per cause bit |
| ev_rx | input | DATA_W | Receive event pulses |
| ev_misc | input | DATA_W | Miscellaneous event pulses |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_o | output | 1 | Level interrupt to the host |

## Verification
A wrong mask or mode state shows up at the ports on the next register read, through the mask view, the masked-cause view or the mode readback. It also shows up on irq_o two clock edges after the event or mask write that exposes it. A lost or wrongly cleared cause bit is caught when the same cause register is read again one read later, in both acknowledge modes, including the cycle where an event collides with a clear. A wrong summary latch shows up as irq_o staying high or dropping at the wrong time around a summary read.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int GRP_N      = 3;
   localparam int GRP_TX     = 0;
   localparam int GRP_RX     = 1;
   localparam int GRP_MISC   = 2;
   localparam int GRP_STRIDE = 8;
   localparam int SUM_BASE   = GRP_N * GRP_STRIDE;

   typedef enum logic [2:0] {
      OFS_CAUSE  = 3'd0,
      OFS_MSET   = 3'd1,
      OFS_MCLR   = 3'd2,
      OFS_MODE   = 3'd3,
      OFS_MASKED = 3'd4,
      OFS_MVAL   = 3'd5
   } grp_ofs_e;

   localparam logic [2:0] SUM_OFS_CAUSE = 3'd0;
   localparam logic [2:0] SUM_OFS_MASK  = 3'd1;

   typedef struct packed {
      logic wr_cause;
      logic rd_cause;
      logic wr_mset;
      logic wr_mclr;
      logic wr_mode;
   } grp_strobe_t;
endpackage

// File: rtl/irqc_cause_group.sv
module irqc_cause_group
   import irqc_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] ev,
   input  grp_strobe_t       stb,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] cause,
   output logic [DATA_W-1:0] masked,
   output logic [DATA_W-1:0] mask,
   output logic              cor,
   output logic              active
);
   logic [DATA_W-1:0] cause_q, mask_q, clr;
   logic              cor_q;

   always_comb begin
      clr = '0;
      if (stb.wr_cause && !cor_q)
         clr = wdata;
      else if (stb.rd_cause && cor_q)
         clr = cause_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cause_q <= '0;
         mask_q  <= '1;
         cor_q   <= 1'b0;
      end else begin
         cause_q <= (cause_q & ~clr) | ev;
         if (stb.wr_mset)
            mask_q <= mask_q | wdata;
         else if (stb.wr_mclr)
            mask_q <= mask_q & ~wdata;
         if (stb.wr_mode)
            cor_q <= &wdata;
      end
   end

   assign cause  = cause_q;
   assign mask   = mask_q;
   assign cor    = cor_q;
   assign masked = cause_q & ~mask_q;
   assign active = |masked;

   p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ev != '0) |=> ((cause & $past(ev)) == $past(ev)));

   p_cor_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (stb.rd_cause && cor && ev == '0) |=> (cause == '0));

   p_w1c_read_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (stb.rd_cause && !cor && ev == '0) |=> (cause == $past(cause)));

   p_mask_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      stb.wr_mset |=> ((mask & $past(wdata)) == $past(wdata)));

   p_mask_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      stb.wr_mclr |=> ((mask & $past(wdata)) == '0));
endmodule

// File: rtl/irqc_summary.sv
module irqc_summary
   import irqc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [GRP_N-1:0] active,
   input  logic             rd,
   input  logic             wr_mask,
   input  logic [GRP_N-1:0] wmask,
   output logic [GRP_N-1:0] sum,
   output logic [GRP_N-1:0] sum_mask,
   output logic             irq
);
   logic [GRP_N-1:0] sum_q, smask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_q   <= '0;
         smask_q <= '1;
      end else begin
         sum_q <= (rd ? '0 : sum_q) | active;
         if (wr_mask)
            smask_q <= wmask;
      end
   end

   assign sum      = sum_q;
   assign sum_mask = smask_q;
   assign irq      = |(sum_q & ~smask_q);

   p_sum_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (active != '0) |=> ((sum & $past(active)) == $past(active)));

   p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && active == '0) |=> (sum == '0));

   p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd) |=> ((sum & $past(sum)) == $past(sum)));

   p_irq_has_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (sum != '0));
endmodule

// File: rtl/irqc_regbus.sv
module irqc_regbus
   import irqc_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 6
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          bus_wr,
   input  logic                          bus_rd,
   input  logic [ADDR_W-1:0]             bus_addr,
   input  logic [GRP_N-1:0][DATA_W-1:0]  grp_cause,
   input  logic [GRP_N-1:0][DATA_W-1:0]  grp_masked,
   input  logic [GRP_N-1:0][DATA_W-1:0]  grp_mask,
   input  logic [GRP_N-1:0]              grp_cor,
   input  logic [GRP_N-1:0]              sum,
   input  logic [GRP_N-1:0]              sum_mask,
   output grp_strobe_t [GRP_N-1:0]       grp_stb,
   output logic                          sum_rd,
   output logic                          sum_wr,
   output logic [DATA_W-1:0]             bus_rdata
);
   localparam int HI_W = ADDR_W - 3;

   logic [HI_W-1:0]   addr_hi;
   logic [2:0]        addr_ofs;
   logic [GRP_N-1:0]  grp_hit;
   logic              sum_hit, mapped;
   logic [DATA_W-1:0] rd_mux, rdata_q;

   assign addr_hi  = bus_addr[ADDR_W-1:3];
   assign addr_ofs = bus_addr[2:0];
   assign sum_hit  = (addr_hi == HI_W'(GRP_N));

   for (genvar g = 0; g < GRP_N; g++) begin : g_dec
      assign grp_hit[g]          = (addr_hi == HI_W'(g));
      assign grp_stb[g].wr_cause = bus_wr && grp_hit[g] && (addr_ofs == OFS_CAUSE);
      assign grp_stb[g].rd_cause = bus_rd && grp_hit[g] && (addr_ofs == OFS_CAUSE);
      assign grp_stb[g].wr_mset  = bus_wr && grp_hit[g] && (addr_ofs == OFS_MSET);
      assign grp_stb[g].wr_mclr  = bus_wr && grp_hit[g] && (addr_ofs == OFS_MCLR);
      assign grp_stb[g].wr_mode  = bus_wr && grp_hit[g] && (addr_ofs == OFS_MODE);
   end

   assign sum_rd = bus_rd && sum_hit && (addr_ofs == SUM_OFS_CAUSE);
   assign sum_wr = bus_wr && sum_hit && (addr_ofs == SUM_OFS_MASK);
   assign mapped = ((|grp_hit) && (addr_ofs <= OFS_MVAL)) ||
                   (sum_hit && (addr_ofs <= SUM_OFS_MASK));

   always_comb begin
      rd_mux = '0;
      for (int g = 0; g < GRP_N; g++) begin
         if (grp_hit[g]) begin
            case (addr_ofs)
               OFS_CAUSE:  rd_mux = grp_cause[g];
               OFS_MODE:   rd_mux = {DATA_W{grp_cor[g]}};
               OFS_MASKED: rd_mux = grp_masked[g];
               OFS_MVAL:   rd_mux = grp_mask[g];
               default:    rd_mux = '0;
            endcase
         end
      end
      if (sum_hit) begin
         if (addr_ofs == SUM_OFS_CAUSE)
            rd_mux = DATA_W'(sum);
         else if (addr_ofs == SUM_OFS_MASK)
            rd_mux = DATA_W'(sum_mask);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata_q <= '0;
      else if (bus_rd)
         rdata_q <= rd_mux;
   end

   assign bus_rdata = rdata_q;

   p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !mapped) |=> (bus_rdata == '0));

   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_rd) |=> $stable(bus_rdata));
endmodule

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl
   import irqc_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] ev_tx,
   input  logic [DATA_W-1:0] ev_rx,
   input  logic [DATA_W-1:0] ev_misc,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o
);
   if (DATA_W < 8 || DATA_W > 64) begin : g_bad_data_w
      $error("grp_irq_ctrl: DATA_W must be within 8..64");
   end
   if ((1 << ADDR_W) <= SUM_BASE + 1) begin : g_bad_addr_w
      $error("grp_irq_ctrl: ADDR_W too narrow for the register map");
   end

   logic [GRP_N-1:0][DATA_W-1:0] ev_all, cause_all, masked_all, mask_all;
   logic [GRP_N-1:0]             cor_all, active_all, sum, sum_mask;
   grp_strobe_t [GRP_N-1:0]      stb_all;
   logic                         sum_rd, sum_wr;

   assign ev_all[GRP_TX]   = ev_tx;
   assign ev_all[GRP_RX]   = ev_rx;
   assign ev_all[GRP_MISC] = ev_misc;

   irqc_regbus #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) regbus_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_wr     (bus_wr),
      .bus_rd     (bus_rd),
      .bus_addr   (bus_addr),
      .grp_cause  (cause_all),
      .grp_masked (masked_all),
      .grp_mask   (mask_all),
      .grp_cor    (cor_all),
      .sum        (sum),
      .sum_mask   (sum_mask),
      .grp_stb    (stb_all),
      .sum_rd     (sum_rd),
      .sum_wr     (sum_wr),
      .bus_rdata  (bus_rdata)
   );

   for (genvar g = 0; g < GRP_N; g++) begin : g_grp
      irqc_cause_group #(.DATA_W(DATA_W)) grp_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .ev     (ev_all[g]),
         .stb    (stb_all[g]),
         .wdata  (bus_wdata),
         .cause  (cause_all[g]),
         .masked (masked_all[g]),
         .mask   (mask_all[g]),
         .cor    (cor_all[g]),
         .active (active_all[g])
      );
   end

   irqc_summary summary_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (active_all),
      .rd       (sum_rd),
      .wr_mask  (sum_wr),
      .wmask    (bus_wdata[GRP_N-1:0]),
      .sum      (sum),
      .sum_mask (sum_mask),
      .irq      (irq_o)
   );
endmodule

// File: tb/grp_irq_ctrl_tb.sv
`timescale 1ns/1ps
module grp_irq_ctrl_tb_top;
   localparam int DW = 32;
   localparam int AW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [DW-1:0] ev_tx = '0, ev_rx = '0, ev_misc = '0;
   logic          bus_wr = 1'b0, bus_rd = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          irq_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   grp_irq_ctrl #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .ev_tx(ev_tx), .ev_rx(ev_rx), .ev_misc(ev_misc),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq_o(irq_o)
   );

   function automatic logic [AW-1:0] ga(input int g, input int ofs);
      return AW'(g * 8 + ofs);
   endfunction

   localparam logic [AW-1:0] A_SUM  = 6'd24;
   localparam logic [AW-1:0] A_SMSK = 6'd25;

   task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic pulse(input int g, input logic [DW-1:0] bits);
      @(negedge clk);
      case (g)
         0: ev_tx = bits;
         1: ev_rx = bits;
         default: ev_misc = bits;
      endcase
      @(negedge clk);
      ev_tx = '0; ev_rx = '0; ev_misc = '0;
   endtask

   task automatic t_reset();
      logic [DW-1:0] d;
      for (int g = 0; g < 3; g++) begin
         bus_read(ga(g, 0), d); check("R1 cause after reset", d, '0);
         bus_read(ga(g, 5), d); check("R1 mask after reset", d, '1);
         bus_read(ga(g, 3), d); check("R1 mode after reset", d, '0);
      end
      bus_read(A_SMSK, d); check("R1 summary mask after reset", d, 32'h7);
      bus_read(A_SUM, d);  check("R1 summary after reset", d, '0);
      check("R1 irq after reset", DW'(irq_o), '0);
   endtask

   task automatic t_latch();
      logic [DW-1:0] d;
      pulse(0, 32'h5);
      bus_read(ga(0, 0), d); check("R2 masked event latches", d, 32'h5);
      bus_read(ga(0, 4), d); check("R6 masked view all masked", d, '0);
      check("R2 irq stays low when masked", DW'(irq_o), '0);
   endtask

   task automatic t_w1c();
      logic [DW-1:0] d;
      bus_write(ga(0, 0), 32'h1);
      bus_read(ga(0, 0), d); check("R3 write one clears", d, 32'h4);
      bus_read(ga(0, 0), d); check("R3 read does not clear", d, 32'h4);
      bus_write(ga(0, 0), 32'h4);
      bus_read(ga(0, 0), d); check("R3 remaining bit cleared", d, '0);
   endtask

   task automatic t_mask();
      logic [DW-1:0] d;
      pulse(1, 32'h30);
      bus_write(ga(1, 2), 32'h30);
      bus_read(ga(1, 5), d); check("R5 mask clear", d, 32'hFFFF_FFCF);
      bus_write(ga(1, 1), 32'h20);
      bus_read(ga(1, 5), d); check("R5 mask set", d, 32'hFFFF_FFEF);
      bus_read(ga(1, 4), d); check("R6 masked view", d, 32'h10);
      bus_read(ga(1, 0), d); check("R6 raw view unchanged", d, 32'h30);
   endtask

   task automatic t_summary();
      logic [DW-1:0] d;
      idle(2);
      check("R9 all-ones summary mask blocks irq", DW'(irq_o), '0);
      bus_write(A_SMSK, 32'h0);
      check("R9 irq after summary unmask", DW'(irq_o), 32'h1);
      bus_read(A_SUM, d); check("R7 summary names RX on bit 1", d, 32'h2);
      check("R7 low byte never all ones", DW'(d[7:0] == 8'hFF), '0);
      bus_write(ga(1, 0), 32'h30);
      idle(1);
      check("R8 summary sticky after cause cleared", DW'(irq_o), 32'h1);
      bus_read(A_SUM, d); check("R8 sticky summary value", d, 32'h2);
      check("R8 irq drops after summary read", DW'(irq_o), '0);
      bus_read(A_SUM, d); check("R8 summary cleared by read", d, '0);
   endtask

   task automatic t_cor();
      logic [DW-1:0] d;
      bus_write(ga(2, 3), '1);
      bus_read(ga(2, 3), d); check("R4 mode reads all ones", d, '1);
      pulse(2, 32'h81);
      bus_write(ga(2, 0), 32'h1);
      bus_read(ga(2, 0), d); check("R4 write ignored in clear-on-read", d, 32'h81);
      bus_read(ga(2, 0), d); check("R4 read cleared cause", d, '0);
      pulse(2, 32'h2);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = ga(2, 0); ev_misc = 32'h2;
      @(negedge clk);
      bus_rd = 1'b0; ev_misc = '0;
      check("R10 read returns pending bit", bus_rdata, 32'h2);
      bus_read(ga(2, 0), d); check("R10 event beats clear-on-read", d, 32'h2);
      bus_read(ga(2, 0), d); check("R10 then cleared", d, '0);
      bus_write(ga(2, 3), 32'h1234);
      bus_read(ga(2, 3), d); check("R4 non-all-ones selects write mode", d, '0);
   endtask

   task automatic t_setwins_w1c();
      logic [DW-1:0] d;
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = ga(0, 0); bus_wdata = 32'h8; ev_tx = 32'h8;
      @(negedge clk);
      bus_wr = 1'b0; ev_tx = '0;
      bus_read(ga(0, 0), d); check("R10 event beats write clear", d, 32'h8);
   endtask

   task automatic t_irq_mix();
      logic [DW-1:0] d;
      bus_write(ga(0, 2), 32'h8);
      idle(2);
      check("R9 irq from TX group", DW'(irq_o), 32'h1);
      bus_write(A_SMSK, 32'h1);
      check("R9 TX blocked by summary mask", DW'(irq_o), '0);
      bus_read(A_SMSK, d); check("R9 summary mask readback", d, 32'h1);
      bus_read(A_SUM, d); check("R7 summary names TX on bit 0", d, 32'h1);
      bus_write(A_SMSK, 32'h0);
      check("R9 irq back after unblock", DW'(irq_o), 32'h1);
   endtask

   task automatic t_unmapped();
      logic [DW-1:0] d;
      bus_read(6'd30, d); check("R11 unmapped high address", d, '0);
      bus_read(ga(0, 6), d); check("R11 unmapped group offset", d, '0);
      bus_read(ga(0, 0), d); check("R11 mapped read after unmapped", d, 32'h8);
      idle(2);
      check("R11 read data holds", bus_rdata, 32'h8);
   endtask

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      t_reset();
      t_latch();
      t_w1c();
      t_mask();
      t_summary();
      t_cor();
      t_setwins_w1c();
      t_irq_mix();
      t_unmapped();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule